// File: doc/BRIEF.md
# GPIO Port with Atomic Set, Clear and Toggle Strobes

This block is a memory-mapped general-purpose I/O port for up to 32 pins on a simple single-cycle register bus. It holds two writable state registers. One is a direction mask that enables each pin's output driver. The other is the output value driven on the pins. Each of the two can be written whole. Each also has three strobe addresses. A write to a strobe address sets, clears or inverts exactly the bits that are 1 in the write data. Software can therefore change single bits with one store, with no read first and no need to mask interrupts.

A read-only input register reports the pin levels after a two-flop synchronizer. Bus reads are combinational. At most one write is accepted per clock, and it takes effect on the clock edge that samples it. Pins whose direction bit is 0 have their output enable low, which the pad ring turns into high impedance.

Top module: `gpio_strobe_port`

## Requirements
- R1: While reset is held and in the cycle after it, the direction and output registers are all zero, so every output enable is low. The synchronized input value is also zero.
- R2: A write to word offset 0x00 replaces the direction register with the write data. A write to 0x10 replaces the output register the same way.
- R3: A write to 0x08 (direction) or 0x18 (output) sets every bit that is 1 in the write data and leaves the other bits unchanged.
- R4: A write to 0x04 (direction) or 0x14 (output) clears every bit that is 1 in the write data and leaves the other bits unchanged.
- R5: A write to 0x0C (direction) or 0x1C (output) inverts every bit that is 1 in the write data and leaves the other bits unchanged.
- R6: Offset 0x20 reads the synchronized pin inputs. A write to 0x20 changes neither the direction register nor the output register.
- R7: A read of 0x04, 0x08 or 0x0C returns the current direction value. A read of 0x14, 0x18 or 0x1C returns the current output value.
- R8: A change on the pin inputs shows up at offset 0x20 exactly two clock edges later, and not after one.
- R9: The output enable of each pin equals its direction bit, and the pin output equals its output-register bit.
- R10: Offsets from 0x24 to 0x3C, and any address whose low two bits are not zero, read as zero and ignore writes.
- R11: When no write is presented, both registers hold their values. A read of any address, including a strobe address, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data or strobe mask |
| bus_rdata | output | DATA_W (32) | Combinational read data |
| pin_in | input | NUM_PINS (32) | Raw pin levels, asynchronous |
| pin_out | output | NUM_PINS (32) | Value driven on each pin |
| pin_oe | output | NUM_PINS (32) | Per-pin output enable |

## Verification
The bench builds the port with its default parameters: 32 pins, a 32-bit data path and a 6-bit byte address. With these values the pin count fills the data word, so strobe masks reach bit 31 as well as bit 0. The 6-bit address covers all sixteen word slots, which brings every reserved slot from 0x24 to 0x3C and the misaligned addresses within reach. The bench keeps its own model of the direction and output values and compares it with bus reads and with the pin outputs after each strobe. It also counts clock edges while a new input pattern passes through the synchronizer.

// File: rtl/gpio_strobe_pkg.sv
package gpio_strobe_pkg;

    // Word slot indices (byte offset / 4); software depends on these values
    localparam int unsigned SLOT_DIR_VAL = 0;
    localparam int unsigned SLOT_DIR_CLR = 1;
    localparam int unsigned SLOT_DIR_SET = 2;
    localparam int unsigned SLOT_DIR_INV = 3;
    localparam int unsigned SLOT_OUT_VAL = 4;
    localparam int unsigned SLOT_OUT_CLR = 5;
    localparam int unsigned SLOT_OUT_SET = 6;
    localparam int unsigned SLOT_OUT_INV = 7;
    localparam int unsigned SLOT_PIN_IN  = 8;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_CLEAR = 3'd2,
        OP_SET   = 3'd3,
        OP_FLIP  = 3'd4
    } bit_op_e;

    typedef struct packed {
        logic    hit_dir;
        logic    hit_out;
        logic    hit_in;
        bit_op_e op;
    } slot_decode_t;

    function automatic slot_decode_t decode_slot(input int unsigned slot);
        slot_decode_t d;
        d = '{hit_dir: 1'b0, hit_out: 1'b0, hit_in: 1'b0, op: OP_HOLD};
        case (slot)
            SLOT_DIR_VAL: begin d.hit_dir = 1'b1; d.op = OP_LOAD;  end
            SLOT_DIR_CLR: begin d.hit_dir = 1'b1; d.op = OP_CLEAR; end
            SLOT_DIR_SET: begin d.hit_dir = 1'b1; d.op = OP_SET;   end
            SLOT_DIR_INV: begin d.hit_dir = 1'b1; d.op = OP_FLIP;  end
            SLOT_OUT_VAL: begin d.hit_out = 1'b1; d.op = OP_LOAD;  end
            SLOT_OUT_CLR: begin d.hit_out = 1'b1; d.op = OP_CLEAR; end
            SLOT_OUT_SET: begin d.hit_out = 1'b1; d.op = OP_SET;   end
            SLOT_OUT_INV: begin d.hit_out = 1'b1; d.op = OP_FLIP;  end
            SLOT_PIN_IN:  begin d.hit_in  = 1'b1;                   end
            default:      ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio_bit_reg.sv
module gpio_bit_reg
    import gpio_strobe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  bit_op_e       op,
    input  logic [W-1:0]  mask,
    output logic [W-1:0]  q
);
    logic [W-1:0] q_nxt;

    always_comb begin
        case (op)
            OP_LOAD:  q_nxt = mask;
            OP_CLEAR: q_nxt = q & ~mask;
            OP_SET:   q_nxt = q | mask;
            OP_FLIP:  q_nxt = q ^ mask;
            default:  q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_strobe_port.sv
module gpio_strobe_port
    import gpio_strobe_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    localparam int SLOT_W      = ADDR_W - 2;
    localparam int SYNC_DEPTH  = 2;

    logic [SLOT_W-1:0]   slot;
    logic                aligned;
    slot_decode_t        dec;
    logic                do_write;
    bit_op_e             dir_op;
    bit_op_e             out_op;
    logic [NUM_PINS-1:0] mask;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] out_q;
    logic [NUM_PINS-1:0] in_sync;

    assign slot     = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign dec      = aligned ? decode_slot(32'(slot))
                              : '{hit_dir: 1'b0, hit_out: 1'b0, hit_in: 1'b0, op: OP_HOLD};
    assign do_write = bus_sel && bus_wr;
    assign mask     = bus_wdata[NUM_PINS-1:0];
    assign dir_op   = (do_write && dec.hit_dir) ? dec.op : OP_HOLD;
    assign out_op   = (do_write && dec.hit_out) ? dec.op : OP_HOLD;

    gpio_bit_reg #(.W(NUM_PINS)) u_dir (
        .clk (clk), .rst (rst), .op (dir_op), .mask (mask), .q (dir_q)
    );

    gpio_bit_reg #(.W(NUM_PINS)) u_out (
        .clk (clk), .rst (rst), .op (out_op), .mask (mask), .q (out_q)
    );

    gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk), .rst (rst), .d (pin_in), .q (in_sync)
    );

    always_comb begin
        bus_rdata = '0;
        if (dec.hit_dir)      bus_rdata = DATA_W'(dir_q);
        else if (dec.hit_out) bus_rdata = DATA_W'(out_q);
        else if (dec.hit_in)  bus_rdata = DATA_W'(in_sync);
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_strobe_port_chk.sv
module gpio_strobe_port_chk #(
    parameter int NUM_PINS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] out_q,
    input logic [NUM_PINS-1:0] in_sync,
    input logic [NUM_PINS-1:0] pin_in
);
    logic [NUM_PINS-1:0] wd;
    logic                wr;
    logic [1:0]          live_cnt;

    assign wd = bus_wdata[NUM_PINS-1:0];
    assign wr = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (rst)                live_cnt <= '0;
        else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == ADDR_W'(6'h00)) |=> (dir_q == $past(wd))); // R2

    AST_DIR_SET_ONES: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == ADDR_W'(6'h08)) |=>
        (((dir_q & $past(wd)) == $past(wd)) &&
         ((dir_q & ~$past(wd)) == ($past(dir_q) & ~$past(wd))))); // R3

    AST_OUT_CLR_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == ADDR_W'(6'h14)) |=>
        (((out_q & $past(wd)) == '0) &&
         ((out_q & ~$past(wd)) == ($past(out_q) & ~$past(wd))))); // R4

    AST_OUT_FLIP: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == ADDR_W'(6'h1C)) |=> (out_q == ($past(out_q) ^ $past(wd)))); // R5

    AST_IN_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == ADDR_W'(6'h20)) |=> ($stable(dir_q) && $stable(out_q))); // R6

    AST_IN_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 2'd2) |-> (in_sync == $past(pin_in, 2))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(dir_q) && $stable(out_q))); // R11
endmodule

bind gpio_strobe_port gpio_strobe_port_chk #(
    .NUM_PINS (NUM_PINS), .DATA_W (DATA_W), .ADDR_W (ADDR_W)
) u_chk (
    .clk (clk), .rst (rst), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .dir_q (dir_q),
    .out_q (out_q), .in_sync (in_sync), .pin_in (pin_in)
);

// File: tb/tb_gpio_strobe_port.sv
`timescale 1ns/1ps
module tb_gpio_strobe_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr  = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] m_dir = '0;
    logic [31:0] m_out = '0;

    always #2 clk = ~clk;

    gpio_strobe_port dut (
        .clk (clk), .rst (rst), .bus_sel (sel), .bus_wr (wr),
        .bus_addr (addr), .bus_wdata (wdata), .bus_rdata (rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic check_state(input string req);
        logic [31:0] v;
        rd_reg(6'h00, v); chk({req, " dir"}, v, m_dir);
        rd_reg(6'h10, v); chk({req, " out"}, v, m_out);
        chk("R9 pin_oe", pin_oe, m_dir);
        chk("R9 pin_out", pin_out, m_out);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check_state("R1");
        rd_reg(6'h20, v); chk("R1 in", v, 32'h0);
    endtask

    task automatic t_load();
        wr_reg(6'h00, 32'hA5A5_0F0F); m_dir = 32'hA5A5_0F0F;
        wr_reg(6'h10, 32'h1234_8001); m_out = 32'h1234_8001;
        check_state("R2");
    endtask

    task automatic t_set();
        wr_reg(6'h08, 32'h8000_00F1); m_dir = m_dir | 32'h8000_00F1;
        wr_reg(6'h18, 32'h0F00_0000); m_out = m_out | 32'h0F00_0000;
        check_state("R3");
    endtask

    task automatic t_clr();
        wr_reg(6'h04, 32'h0000_0F01); m_dir = m_dir & ~32'h0000_0F01;
        wr_reg(6'h14, 32'h8000_0001); m_out = m_out & ~32'h8000_0001;
        check_state("R4");
    endtask

    task automatic t_tgl();
        wr_reg(6'h0C, 32'hFFFF_0000); m_dir = m_dir ^ 32'hFFFF_0000;
        wr_reg(6'h1C, 32'h8000_0003); m_out = m_out ^ 32'h8000_0003;
        check_state("R5");
        wr_reg(6'h1C, 32'h0); check_state("R5 zero mask");
    endtask

    task automatic t_mirror();
        logic [31:0] v;
        rd_reg(6'h04, v); chk("R7 dir clr addr", v, m_dir);
        rd_reg(6'h08, v); chk("R7 dir set addr", v, m_dir);
        rd_reg(6'h0C, v); chk("R7 dir tgl addr", v, m_dir);
        rd_reg(6'h14, v); chk("R7 out clr addr", v, m_out);
        rd_reg(6'h18, v); chk("R7 out set addr", v, m_out);
        rd_reg(6'h1C, v); chk("R7 out tgl addr", v, m_out);
        @(negedge clk);
        check_state("R11 after reads");
    endtask

    task automatic t_input();
        logic [31:0] v;
        @(negedge clk); pin_in = 32'hC3C3_5AA5;
        @(negedge clk); rd_reg(6'h20, v); chk("R8 one edge", v, 32'h0);
        @(negedge clk); rd_reg(6'h20, v); chk("R8 two edges", v, 32'hC3C3_5AA5);
        wr_reg(6'h20, 32'hFFFF_FFFF);
        check_state("R6");
        rd_reg(6'h20, v); chk("R6 in", v, 32'hC3C3_5AA5);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        for (int a = 6'h24; a <= 6'h3C; a += 4) begin
            wr_reg(6'(a), 32'hFFFF_FFFF);
            rd_reg(6'(a), v); chk("R10 reserved read", v, 32'h0);
        end
        wr_reg(6'h09, 32'hFFFF_FFFF);
        rd_reg(6'h01, v); chk("R10 misaligned read", v, 32'h0);
        check_state("R10");
    endtask

    task automatic t_idle();
        repeat (5) @(negedge clk);
        check_state("R11");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load();
        t_set();
        t_clr();
        t_tgl();
        t_mirror();
        t_input();
        t_reserved();
        t_idle();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule